// File: doc/BRIEF.md
# Supply Start-Up and Hiccup Protection Sequencer

This block is the supervisory state machine of an off-line switching converter controller. It reads digitized comparator flags for the supply rail, plus flags for sufficient mains, over-current and brownout. From these it decides when the high-voltage start-up current source charges the supply capacitor and when the power switch may run. It also decides when a protection stop is held.

At power-up the block charges the supply until the turn-on flag rises, then enables switching. While the converter runs, the start-up source tops up the supply during switch off-times whenever the rail has sagged below the restart level. The over-current comparator result is taken once per switching cycle, on the switch turn-off event. A first trip gives a warning, and a second consecutive trip stops the converter. A brownout also stops it. A stop is held until the supply decays through the turn-off level. Recharging then waits until the rail is nearly discharged, and this produces hiccup restart cycles.

Top module: `sup_hiccup_seq`

## Requirements
- R1: During reset and on its release the status output is 0 (charging), switching enable and the fault-latched output are low, and the start-up current enable follows the mains-sufficient flag.
- R2: In the charging state (status 0) the start-up current enable equals the mains-sufficient flag, and switching is disabled. One clock after a cycle with the turn-on flag high, the status is 1 (running), switching is enabled and the start-up current enable drops.
- R3: In the running or warning states, a cycle with the below-restart flag high arms self-supply from the next clock. While armed, the start-up current enable equals mains-sufficient AND switch-off. A cycle with the turn-on flag high disarms it from the next clock.
- R4: The over-current flag is acted on only in a cycle where the turn-off event is high. A trip without that event has no effect. A first trip in the running state moves to warning (status 2), and switching stays enabled.
- R5: A turn-off event without a trip while in warning returns the machine to running (status 1).
- R6: A turn-off event with a trip while in warning (the second consecutive trip) moves to the fault state (status 3). There, switching enable and start-up current enable are low and the fault-latched output is high.
- R7: The fault state holds, with the start-up source off even when the supply is below the restart level, until a cycle with the below-turn-off flag high. It then moves to waiting-for-restart (status 4), where the fault-latched output is low and the start-up source stays off.
- R8: Waiting-for-restart moves to charging (status 0) one clock after a cycle with the below-release (about 5 V) flag high.
- R9: A brownout flag in the running or warning state moves to the fault state on the next clock.
- R10: The below-turn-off flag in the running or warning state, with no brownout, returns to charging and clears the strike history. The first trip after the next start then gives warning, not fault.
- R11: Brownout has priority over undervoltage: when both flags are high in the running state, the next state is fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_above_on | input | 1 | Supply at or above turn-on threshold |
| vcc_below_restart | input | 1 | Supply below self-supply restart level |
| vcc_below_off | input | 1 | Supply below turn-off level |
| vcc_below_release | input | 1 | Supply below hiccup release level (about 5 V) |
| mains_ok | input | 1 | Drain voltage high enough for the start-up source |
| sw_off | input | 1 | Power switch currently off |
| sw_off_evt | input | 1 | One-clock pulse at switch turn-off |
| oc_trip | input | 1 | Sense level exceeded the hiccup over-current level this cycle |
| brownout | input | 1 | On-time sensed current stayed below its minimum |
| hv_en | output | 1 | Start-up current source enable |
| sw_en | output | 1 | Switching enable |
| fault_latched | output | 1 | Protection stop held |
| state_o | output | 3 | Status: 0 charging, 1 running, 2 warning, 3 fault, 4 waiting for restart |

## Verification
The hardest situation to reach is a stale strike count. This happens when the converter is in warning, the supply collapses, and the machine restarts through charging. If the count survived, the first trip after restart would be taken as the second strike. The stimulus reaches this case by driving a trip into warning and then raising the below-turn-off flag. It then recharges with the turn-on flag and applies a single trip, which must give warning. Self-supply gating is also checked by toggling the switch-off input while armed.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        ST_CHARGE = 3'd0,
        ST_RUN    = 3'd1,
        ST_WARN   = 3'd2,
        ST_FAULT  = 3'd3,
        ST_WAIT   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic above_on;
        logic below_restart;
        logic below_off;
        logic below_release;
    } vcc_lvl_t;

    function automatic logic is_active(input seq_state_e st);
        return (st == ST_RUN) || (st == ST_WARN);
    endfunction

endpackage

// File: rtl/sup_selfsup_keeper.sv
module sup_selfsup_keeper (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic below_restart,
    input  logic above_on,
    output logic armed
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst || !active)      armed_q <= 1'b0;
        else if (above_on)       armed_q <= 1'b0;
        else if (below_restart)  armed_q <= 1'b1;
    end

    assign armed = armed_q;

    p_arm_on_sag_r3: assert property (@(posedge clk) disable iff (rst)
        (active && below_restart && !above_on) |=> armed);

    p_disarm_at_on_r3: assert property (@(posedge clk) disable iff (rst)
        (active && above_on) |=> !armed);

endmodule

// File: rtl/sup_ocp_strikes.sv
module sup_ocp_strikes #(
    parameter int STRIKE_LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic evt,
    input  logic trip,
    output logic limit_hit
);
    localparam int CW = $clog2(STRIKE_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(STRIKE_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !arm)   cnt_q <= '0;
        else if (evt)      cnt_q <= trip ? (cnt_q + 1'b1) : '0;
    end

    assign limit_hit = arm && evt && trip && (cnt_q == LAST);

    p_strike_counts_r4: assert property (@(posedge clk) disable iff (rst)
        (arm && evt && trip && !limit_hit) |=> (cnt_q != '0));

    p_clean_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (arm && evt && !trip) |=> (cnt_q == '0));

endmodule

// File: rtl/sup_hiccup_seq.sv
module sup_hiccup_seq
    import sup_pkg::*;
#(
    parameter int STRIKE_LIMIT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_above_on,
    input  logic       vcc_below_restart,
    input  logic       vcc_below_off,
    input  logic       vcc_below_release,
    input  logic       mains_ok,
    input  logic       sw_off,
    input  logic       sw_off_evt,
    input  logic       oc_trip,
    input  logic       brownout,
    output logic       hv_en,
    output logic       sw_en,
    output logic       fault_latched,
    output logic [2:0] state_o
);
    vcc_lvl_t   lvl;
    seq_state_e st_q, st_d;
    logic       active, armed, hit;

    assign lvl = '{above_on:      vcc_above_on,
                   below_restart: vcc_below_restart,
                   below_off:     vcc_below_off,
                   below_release: vcc_below_release};

    assign active = is_active(st_q);

    sup_selfsup_keeper u_keep (
        .clk(clk), .rst(rst), .active(active),
        .below_restart(lvl.below_restart), .above_on(lvl.above_on),
        .armed(armed)
    );

    sup_ocp_strikes #(.STRIKE_LIMIT(STRIKE_LIMIT)) u_ocp (
        .clk(clk), .rst(rst), .arm(active),
        .evt(sw_off_evt), .trip(oc_trip), .limit_hit(hit)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CHARGE: if (lvl.above_on) st_d = ST_RUN;
            ST_RUN, ST_WARN: begin
                if (brownout)            st_d = ST_FAULT;
                else if (lvl.below_off)  st_d = ST_CHARGE;
                else if (sw_off_evt) begin
                    if (!oc_trip)        st_d = ST_RUN;
                    else if (hit)        st_d = ST_FAULT;
                    else                 st_d = ST_WARN;
                end
            end
            ST_FAULT:  if (lvl.below_off)     st_d = ST_WAIT;
            ST_WAIT:   if (lvl.below_release) st_d = ST_CHARGE;
            default:                          st_d = ST_CHARGE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_CHARGE;
        else     st_q <= st_d;
    end

    always_comb begin
        if (st_q == ST_CHARGE) hv_en = mains_ok;
        else if (active)       hv_en = mains_ok && sw_off && armed;
        else                   hv_en = 1'b0;
    end

    assign sw_en         = active;
    assign fault_latched = (st_q == ST_FAULT);
    assign state_o       = st_q;

    p_charge_to_run_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 && vcc_above_on) |=> (state_o == 3'd1 && sw_en));

    p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (fault_latched && !vcc_below_off) |=> fault_latched);

    p_fault_release_r7: assert property (@(posedge clk) disable iff (rst)
        (fault_latched && vcc_below_off) |=> (state_o == 3'd4 && !hv_en));

    p_wait_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && vcc_below_release) |=> (state_o == 3'd0));

    p_brownout_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (sw_en && brownout) |=> fault_latched);

    p_uvlo_back_r10: assert property (@(posedge clk) disable iff (rst)
        (sw_en && !brownout && vcc_below_off) |=> (state_o == 3'd0));

endmodule

// File: tb/sup_hiccup_seq_test.sv
module sup_hiccup_seq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic on_f = 0, rs_f = 1, off_f = 1, rel_f = 1, mains = 1;
    logic swoff = 0, evt = 0, trip = 0, bo = 0;
    logic hv, sw, flt;
    logic [2:0] st;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [2:0] st;
        logic       sw, hv, flt;
    } exp_t;
    exp_t q[$];
    event item_ev;

    always #2 clk = ~clk;

    sup_hiccup_seq uut (
        .clk(clk), .rst(rst),
        .vcc_above_on(on_f), .vcc_below_restart(rs_f),
        .vcc_below_off(off_f), .vcc_below_release(rel_f),
        .mains_ok(mains), .sw_off(swoff), .sw_off_evt(evt),
        .oc_trip(trip), .brownout(bo),
        .hv_en(hv), .sw_en(sw), .fault_latched(flt), .state_o(st)
    );

    // monitor: pops each expected item and compares with the ports
    initial begin
        forever begin
            @(item_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (st !== e.st || sw !== e.sw || hv !== e.hv || flt !== e.flt) begin
                    fails++;
                    $display("FAIL %s: got st=%0d sw=%b hv=%b flt=%b exp st=%0d sw=%b hv=%b flt=%b",
                             e.tag, st, sw, hv, flt, e.st, e.sw, e.hv, e.flt);
                end
            end
        end
    end

    // driver: one clock, then queue what the ports must show
    task automatic step(input string tag, input logic [2:0] es,
                        input logic esw, input logic ehv, input logic ef);
        exp_t e;
        @(posedge clk);
        #1;
        e.tag = tag; e.st = es; e.sw = esw; e.hv = ehv; e.flt = ef;
        q.push_back(e);
        -> item_ev;
        #1;
    endtask

    initial begin
        step("R1 reset", 3'd0, 0, 1, 0);
        step("R1 reset held", 3'd0, 0, 1, 0);
        rst = 0; mains = 0;
        step("R2 no mains", 3'd0, 0, 0, 0);
        mains = 1; off_f = 0; rs_f = 0; rel_f = 0;
        step("R2 charging", 3'd0, 0, 1, 0);
        on_f = 1;
        step("R2 turn-on", 3'd1, 1, 0, 0);
        on_f = 0; rs_f = 1; swoff = 1;
        step("R3 self-supply armed", 3'd1, 1, 1, 0);
        rs_f = 0; swoff = 0;
        step("R3 off only in sw_off", 3'd1, 1, 0, 0);
        swoff = 1;
        step("R3 still armed", 3'd1, 1, 1, 0);
        on_f = 1;
        step("R3 disarmed", 3'd1, 1, 0, 0);
        on_f = 0; swoff = 0; trip = 1;
        step("R4 trip without event", 3'd1, 1, 0, 0);
        evt = 1;
        step("R4 first strike", 3'd2, 1, 0, 0);
        trip = 0;
        step("R5 clean cycle", 3'd1, 1, 0, 0);
        trip = 1;
        step("R4 strike again", 3'd2, 1, 0, 0);
        step("R6 second strike", 3'd3, 0, 0, 1);
        evt = 0; trip = 0; rs_f = 1; swoff = 1;
        step("R7 fault holds hv off", 3'd3, 0, 0, 1);
        off_f = 1;
        step("R7 fault release", 3'd4, 0, 0, 0);
        step("R8 waiting", 3'd4, 0, 0, 0);
        rel_f = 1;
        step("R8 restart charge", 3'd0, 0, 1, 0);
        rel_f = 0; off_f = 0; rs_f = 0; on_f = 1; swoff = 0;
        step("R8 running again", 3'd1, 1, 0, 0);
        on_f = 0; bo = 1;
        step("R9 brownout", 3'd3, 0, 0, 1);
        bo = 0; off_f = 1;
        step("R9 release", 3'd4, 0, 0, 0);
        rel_f = 1;
        step("R9 recharge", 3'd0, 0, 1, 0);
        rel_f = 0; off_f = 0; on_f = 1;
        step("R10 run", 3'd1, 1, 0, 0);
        on_f = 0; evt = 1; trip = 1;
        step("R10 warn", 3'd2, 1, 0, 0);
        evt = 0; trip = 0; off_f = 1;
        step("R10 undervoltage", 3'd0, 0, 1, 0);
        off_f = 0; on_f = 1;
        step("R10 run after uvlo", 3'd1, 1, 0, 0);
        on_f = 0; evt = 1; trip = 1;
        step("R10 history cleared", 3'd2, 1, 0, 0);
        evt = 0; trip = 0;
        step("R5 idle in warn", 3'd2, 1, 0, 0);
        evt = 1;
        step("R5 back to run", 3'd1, 1, 0, 0);
        evt = 0; bo = 1; off_f = 1;
        step("R11 brownout priority", 3'd3, 0, 0, 1);
        bo = 0;
        step("R11 release", 3'd4, 0, 0, 0);
        @(posedge clk); #1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule